// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block gathers seven interrupt sources into one active-high request line. Each source sends a one-cycle event pulse that sets a sticky flag bit. A host on a byte-wide register bus reads the flags, clears them, and changes a seven-bit enable mask. The register index comes from the top four address bits. Index 13 is the flag register and index 14 is the enable register. A read of index 10, the shift-register data, clears the shift-register flag as a side effect. Other blocks can also clear flags through a side-clear input, for example when a timer's counter is read.

When the flag register is read, bit 7 is a summary bit. It is 1 when some flag is set whose enable bit is also set. Flags are cleared by writing ones to their positions. The enable register is written with a command in bit 7. A 1 there sets the enable bits given by the low seven data bits. A 0 there clears them. The enable register always reads back with bit 7 high. The request output is registered, so it follows the flag and enable state one clock later.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all flags and enables are 0, irq_o is 0, the flag register reads 8'h00 and the enable register reads 8'h80.
- R2: A 1 on evt_i[k] for one cycle sets flag k, and the flag stays set after the pulse ends. Source positions: bit 6 is timer 1, bit 5 is timer 2, bit 2 is the shift register, and bits 0, 1, 3 and 4 are generic sources.
- R3: A read with addr[12:9] = 13 returns the flags in bits 6:0. Bit 7 is 1 exactly when (flags & enables) is nonzero.
- R4: A write to index 13 clears each flag whose position holds a 1 in wdata[6:0]. Every other flag keeps its value.
- R5: A write to index 14 with wdata[7] = 1 ORs wdata[6:0] into the enables.
- R6: A write to index 14 with wdata[7] = 0 clears each enable whose bit in wdata[6:0] is 1. Every other enable keeps its value.
- R7: A read of index 14 returns the enables in bits 6:0, with bit 7 always 1.
- R8: A read of index 10 clears flag bit 2. No other flag changes.
- R9: A 1 on side_clr_i[k] clears flag k.
- R10: If an event and any clear reach the same flag in the same cycle, the flag ends up set.
- R11: irq_o equals the OR of (flags & enables) as they stood at the previous clock edge. It therefore changes one clock after the flags or enables change.
- R12: Writes to any index other than 13 and 14 leave the flags and the enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register bus select |
| rd_en | input | 1 | Read strobe, qualified by cs |
| wr_en | input | 1 | Write strobe, qualified by cs |
| addr | input | 13 | Byte address; bits 12:9 give the register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational; 0 for indices not handled here |
| evt_i | input | 7 | Event pulses that set flags |
| side_clr_i | input | 7 | Side-effect clears from other blocks |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The main test is a sequence of register operations and event pulses. It covers timer events, a mixed timer and shift-register event, and the four generic sources together. Each of these is run with enables that hide some of the set flags and expose others. This shows that the summary bit and irq_o depend on the AND of flags and enables, not on either one alone. Enable writes use both command polarities with overlapping masks, which catches a design that replaces the mask instead of setting or clearing bits. Directed cases then check set-over-clear priority for each clear path (host write, shift-register read, side clear), the one-clock delay of irq_o, and the reset values.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int unsigned NSRC     = 7;
  localparam int unsigned IDX_W    = 4;
  localparam logic [IDX_W-1:0] IDX_SR   = 4'd10;
  localparam logic [IDX_W-1:0] IDX_FLAG = 4'd13;
  localparam logic [IDX_W-1:0] IDX_EN   = 4'd14;
  localparam logic [NSRC-1:0]  SR_CLR_MASK = 7'b000_0100;

  // next value of one flag bit: a set event wins over every clear
  function automatic logic flag_bit_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  // enable mask update from a command byte (bit 7 selects set or clear)
  function automatic logic [NSRC-1:0] en_cmd_apply(input logic [NSRC-1:0] en,
                                                   input logic [NSRC:0]   cmd);
    if (cmd[NSRC]) return en | cmd[NSRC-1:0];
    else           return en & ~cmd[NSRC-1:0];
  endfunction

  // any enabled flag pending
  function automatic logic pend_any(input logic [NSRC-1:0] f, input logic [NSRC-1:0] e);
    return |(f & e);
  endfunction
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_flag_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              cs,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              flag_wr,
  output logic              en_wr,
  output logic              flag_rd,
  output logic              en_rd,
  output logic              sr_rd
);
  localparam int unsigned LOW_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] idx;
  logic [LOW_W-1:0] unused_low;

  assign idx        = addr[ADDR_W-1 -: IDX_W];
  assign unused_low = addr[LOW_W-1:0];

  assign flag_wr = cs & wr_en & (idx == IDX_FLAG);
  assign en_wr   = cs & wr_en & (idx == IDX_EN);
  assign flag_rd = cs & rd_en & (idx == IDX_FLAG);
  assign en_rd   = cs & rd_en & (idx == IDX_EN);
  assign sr_rd   = cs & rd_en & (idx == IDX_SR);
endmodule

// File: rtl/irq_flag_store.sv
module irq_flag_store
  import irq_flag_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flag_q
);
  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[k] <= 1'b0;
      else        flag_q[k] <= flag_bit_next(flag_q[k], set_i[k], clr_i[k]);
    end
  end
endmodule

// File: rtl/irq_enable_store.sv
module irq_enable_store
  import irq_flag_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [NSRC:0]   cmd_i,
  output logic [NSRC-1:0] en_q
);
  logic [NSRC-1:0] en_n;

  always_comb en_n = wr_i ? en_cmd_apply(en_q, cmd_i) : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_n;
  end
endmodule

// File: rtl/irq_request.sv
module irq_request
  import irq_flag_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] flag_i,
  input  logic [NSRC-1:0] en_i,
  output logic            pending_o,
  output logic            irq_o
);
  assign pending_o = pend_any(flag_i, en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pending_o;
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [6:0]        evt_i,
  input  logic [6:0]        side_clr_i,
  output logic              irq_o
);
  logic            flag_wr, en_wr, flag_rd, en_rd, sr_rd;
  logic [NSRC-1:0] flag_q, en_q, clr_w;
  logic            pending;

  irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cs(cs), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .flag_wr(flag_wr), .en_wr(en_wr), .flag_rd(flag_rd),
    .en_rd(en_rd), .sr_rd(sr_rd)
  );

  // all clear paths merged; the store gives set priority
  assign clr_w = (flag_wr ? wdata[NSRC-1:0] : '0)
               | (sr_rd   ? SR_CLR_MASK     : '0)
               | side_clr_i;

  irq_flag_store u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(clr_w), .flag_q(flag_q)
  );

  irq_enable_store u_en (
    .clk(clk), .rst_n(rst_n), .wr_i(en_wr), .cmd_i(wdata), .en_q(en_q)
  );

  irq_request u_req (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_q), .en_i(en_q),
    .pending_o(pending), .irq_o(irq_o)
  );

  always_comb begin
    if (flag_rd)    rdata = {pending, flag_q};
    else if (en_rd) rdata = {1'b1, en_q};
    else            rdata = 8'h00;
  end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] evt_i,
  input logic [6:0] side_clr_i,
  input logic [6:0] flag_q,
  input logic [6:0] en_q,
  input logic       flag_wr,
  input logic       en_wr,
  input logic       en_rd,
  input logic       sr_rd,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       pending,
  input logic       irq_o
);
  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));
  // set-over-clear priority, R10
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && (|(evt_i & wdata[6:0]))) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));
  p_host_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && evt_i == 7'd0) |=> ((flag_q & $past(wdata[6:0])) == 7'd0));
  p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && wdata[7]) |=> ((en_q & $past(wdata[6:0])) == $past(wdata[6:0])));
  p_en_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !wdata[7]) |=> ((en_q & $past(wdata[6:0])) == 7'd0));
  p_en_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q));
  p_en_read_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_rd |-> rdata[7]);
  p_sr_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rd && !evt_i[2]) |=> !flag_q[2]);
  p_side_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(side_clr_i & ~evt_i)) |=> ((flag_q & $past(side_clr_i & ~evt_i)) == 7'd0));
  p_irq_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> irq_o);
  p_irq_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> !irq_o);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .side_clr_i(side_clr_i),
  .flag_q(flag_q), .en_q(en_q), .flag_wr(flag_wr), .en_wr(en_wr),
  .en_rd(en_rd), .sr_rd(sr_rd), .wdata(wdata), .rdata(rdata),
  .pending(pending), .irq_o(irq_o)
);

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [6:0]  evt_i = '0, side_clr_i = '0;
  logic        irq_o;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_flag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .evt_i(evt_i),
    .side_clr_i(side_clr_i), .irq_o(irq_o)
  );

  localparam logic [1:0] OP_NONE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
  // {op, idx, data, evt, exp_flag_read, exp_en_read, exp_irq}
  localparam int NV = 12;
  localparam logic [37:0] VEC [NV] = '{
    {OP_NONE, 4'd0,  8'h00, 7'h40, 8'h40, 8'h80, 1'b0},  // R2 timer 1
    {OP_WR,   4'd14, 8'hC0, 7'h00, 8'hC0, 8'hC0, 1'b1},  // R5 R3 R11
    {OP_NONE, 4'd0,  8'h00, 7'h24, 8'hE4, 8'hC0, 1'b1},  // R2 timer 2 + shift
    {OP_WR,   4'd13, 8'h40, 7'h00, 8'h24, 8'hC0, 1'b0},  // R4
    {OP_WR,   4'd14, 8'h84, 7'h00, 8'hA4, 8'hC4, 1'b1},  // R5 R7
    {OP_RD,   4'd10, 8'h00, 7'h00, 8'h20, 8'hC4, 1'b0},  // R8
    {OP_WR,   4'd14, 8'h40, 7'h00, 8'h20, 8'h84, 1'b0},  // R6
    {OP_WR,   4'd3,  8'hFF, 7'h00, 8'h20, 8'h84, 1'b0},  // R12
    {OP_NONE, 4'd0,  8'h00, 7'h1B, 8'h3B, 8'h84, 1'b0},  // R2 generic
    {OP_WR,   4'd14, 8'h88, 7'h00, 8'hBB, 8'h8C, 1'b1},  // R5 R3
    {OP_WR,   4'd13, 8'h7F, 7'h00, 8'h00, 8'h8C, 1'b0},  // R4
    {OP_WR,   4'd14, 8'h7F, 7'h00, 8'h00, 8'h80, 1'b0}   // R6
  };

  function automatic logic [12:0] mk_addr(input logic [3:0] idx);
    return {idx, 9'h1A5};
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [3:0] idx, output logic [7:0] val);
    cs = 1'b1; rd_en = 1'b1; addr = mk_addr(idx);
    #1 val = rdata;
    cs = 1'b0; rd_en = 1'b0;
  endtask

  // one cycle of access plus events, then one more edge for irq_o
  task automatic step(input logic [1:0] op, input logic [3:0] idx,
                      input logic [7:0] d, input logic [6:0] ev, input logic [6:0] sc);
    @(negedge clk);
    cs = (op != OP_NONE); wr_en = (op == OP_WR); rd_en = (op == OP_RD);
    addr = mk_addr(idx); wdata = d; evt_i = ev; side_clr_i = sc;
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b0; rd_en = 1'b0; evt_i = '0; side_clr_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    read_reg(4'd13, v); check8("R1 flags", v, 8'h00);
    read_reg(4'd14, v); check8("R1 enables", v, 8'h80);
    check8("R1 irq", {7'd0, irq_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][37:36], VEC[i][35:32], VEC[i][31:24], VEC[i][23:17], 7'h00);
      @(negedge clk);
      check8($sformatf("R11 vec%0d irq", i), {7'd0, irq_o}, {7'd0, VEC[i][0]});
      read_reg(4'd13, v); check8($sformatf("R3 vec%0d flags", i), v, VEC[i][16:9]);
      read_reg(4'd14, v); check8($sformatf("R7 vec%0d enables", i), v, VEC[i][8:1]);
    end

    // R10: host clear and event on bit 0 in the same cycle
    step(OP_WR, 4'd13, 8'h01, 7'h01, 7'h00);
    read_reg(4'd13, v); check8("R10 host clear vs event", v, 8'h01);
    // R10: shift read and shift event together
    step(OP_RD, 4'd10, 8'h00, 7'h04, 7'h00);
    read_reg(4'd13, v); check8("R10 shift read vs event", v, 8'h05);
    // R8 then: shift read clears only bit 2
    step(OP_RD, 4'd10, 8'h00, 7'h00, 7'h00);
    read_reg(4'd13, v); check8("R8 only bit 2", v, 8'h01);
    // R9 side clear, and R10 with side clear
    step(OP_NONE, 4'd0, 8'h00, 7'h60, 7'h00);
    step(OP_NONE, 4'd0, 8'h00, 7'h00, 7'h41);
    read_reg(4'd13, v); check8("R9 side clear", v, 8'h20);
    step(OP_NONE, 4'd0, 8'h00, 7'h20, 7'h20);
    read_reg(4'd13, v); check8("R10 side clear vs event", v, 8'h20);

    // R11 timing: enable bit 5, irq follows one clock after en change
    @(negedge clk);
    cs = 1'b1; wr_en = 1'b1; addr = mk_addr(4'd14); wdata = 8'hA0;
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b0;
    check8("R11 irq not yet", {7'd0, irq_o}, 8'h00);
    @(negedge clk);
    check8("R11 irq one clock later", {7'd0, irq_o}, 8'h01);
    // R12 write to shift index ignored
    step(OP_WR, 4'd10, 8'h7F, 7'h00, 7'h00);
    read_reg(4'd13, v); check8("R12 flags kept", v, 8'hA0);
    read_reg(4'd14, v); check8("R12 enables kept", v, 8'hA0);

    // R1 reset again mid-run
    rst_n = 1'b0; #1;
    read_reg(4'd13, v); check8("R1 flags after reset", v, 8'h00);
    check8("R1 irq after reset", {7'd0, irq_o}, 8'h00);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule